// File: doc/BRIEF.md
# Display PLL divisor bank selector

This block is the register-file front end of a display clock synthesizer. It stores three independently programmable sets of loop parameters (a feedback divisor M, a reference divisor N and a post divisor P), plus one extra set reserved for an LCD panel clock. A host programs all of them through a single-cycle memory-mapped write port and can read every register back through a combinational read port.

Only one parameter set drives the synthesizer at any time. A two-bit select field in a miscellaneous-output register names the active set. When both the top bit and the bottom bit of an LCD control register are set, the LCD set is used and the field's value does not matter. The parameters are not taken live from the bank registers. A write to the miscellaneous-output register copies the chosen set into a working register file that feeds the synthesizer, and that copy raises a one-cycle load strobe. Editing a bank therefore never disturbs a running clock until the host selects again.

Word offsets: 0, 1 and 2 hold the divisors of banks 0, 1 and 2. Offset 3 holds the LCD divisor. Offset 4 holds the post-divisor bytes. Offset 5 is the miscellaneous-output register and offset 6 the LCD control register. Offset 7 is the working divisor and offset 8 the working post divisor. Reads of any other offset return 0.

Top module: `dpll_bank_sel`

## Requirements
- R1: Each divisor register at offsets 0..3 (banks 0, 1, 2 and LCD) stores M from write bits [9:0] and N from write bits [25:16]. It reads back with all other bits 0, and writing one leaves the others unchanged.
- R2: The post-divisor register at offset 4 holds bank k's P in bits [8k+7:8k] for k = 0..2, and the LCD set's P in bits [31:24].
- R3: After reset, bank 0 holds M=103, N=20, P=2 and bank 1 holds M=170, N=30, P=2. Bank 2 and the LCD set are 0, the miscellaneous-output register is 0, the working file equals bank 0, `pll_src` is 0 and `pll_load` is low.
- R4: A write to offset 5 with bits [3:2] = 00, 01 or 10 (and no LCD override) copies bank 0, 1 or 2 into the working file. The result is visible on `pll_m`/`pll_n`/`pll_p` in the cycle after the write.
- R5: A write to offset 5 with bits [3:2] = 11 and no LCD override leaves the working file and `pll_src` unchanged and raises no strobe. Offset 5 still reads back the written byte.
- R6: While bits 31 and 0 of the LCD control register (offset 6) are both 1, a write to offset 5 loads the LCD set whatever its bits [3:2] hold. If either bit is 0, the select field rules apply.
- R7: Writing a bank's divisor or P byte, or the LCD control register, does not change the working file, even for the active bank. The change takes effect only on the next write to offset 5.
- R8: Offsets 7 and 8 read the working file (divisor layout as R1, P in bits [7:0]) and ignore writes.
- R9: `pll_load` is high for exactly one cycle after each transfer and is low otherwise.
- R10: `pll_src` gives the set loaded by the last transfer: 0, 1 or 2 for a bank, 3 for the LCD set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word offset of the read |
| rd_data | output | 32 | Combinational read data |
| pll_m | output | 10 | Working feedback divisor |
| pll_n | output | 10 | Working reference divisor |
| pll_p | output | 8 | Working post divisor |
| pll_load | output | 1 | One-cycle strobe on a working-file update |
| pll_src | output | 2 | Set that drove the last transfer (3 = LCD) |

## Verification
A wrong active-set index or a missed override shows on the cycle after a select write: the working divisors differ from the bank the host chose, and `pll_src` names the wrong set. A working file that tracks bank writes live shows the first time the active bank is edited, as a changed `pll_m` with no strobe. A stray or stretched strobe shows as an extra load that the scoreboard did not expect. A corrupted bank register stays hidden until it is selected or read back. For that reason the bench reads back every offset and selects each bank after editing it.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
    localparam int M_W     = 10;
    localparam int N_W     = 10;
    localparam int P_W     = 8;
    localparam int DW      = 32;
    localparam int AW      = 4;
    localparam int N_BANKS = 3;
    localparam int N_SRC   = N_BANKS + 1;
    localparam int SRC_W   = $clog2(N_SRC);
    localparam int M_LSB   = 0;
    localparam int N_LSB   = 16;
    localparam int SEL_LSB = 2;
    localparam int MISC_W  = 8;

    localparam logic [AW-1:0] OFS_DIV0   = 4'd0;
    localparam logic [AW-1:0] OFS_PSEL   = 4'd4;
    localparam logic [AW-1:0] OFS_MISC   = 4'd5;
    localparam logic [AW-1:0] OFS_LCDCTL = 4'd6;
    localparam logic [AW-1:0] OFS_WDIV   = 4'd7;
    localparam logic [AW-1:0] OFS_WP     = 4'd8;

    localparam logic [SRC_W-1:0] SRC_LCD = SRC_W'(N_BANKS);

    typedef struct packed {
        logic [P_W-1:0] p;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } pll_par_t;

    localparam pll_par_t RST_BANK0 = pll_par_t'({8'd2, 10'd20, 10'd103});
    localparam pll_par_t RST_BANK1 = pll_par_t'({8'd2, 10'd30, 10'd170});

    function automatic pll_par_t rst_par(int k);
        case (k)
            0:       return RST_BANK0;
            1:       return RST_BANK1;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] pack_div(pll_par_t x);
        logic [DW-1:0] w;
        w = '0;
        w[M_LSB +: M_W] = x.m;
        w[N_LSB +: N_W] = x.n;
        return w;
    endfunction

    function automatic logic [SRC_W-1:0] pick_src(logic [1:0] code,
                                                  logic [SRC_W-1:0] prev,
                                                  logic lcd);
        if (lcd)                return SRC_LCD;
        else if (code == 2'b11) return prev;
        else                    return SRC_W'(code);
    endfunction
endpackage

// File: rtl/dpll_bank_file.sv
module dpll_bank_file
    import dpll_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    output pll_par_t [N_SRC-1:0] bank_q
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_bank
        pll_par_t r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= rst_par(g);
            end else if (wr_en) begin
                if (wr_addr == OFS_DIV0 + AW'(g)) begin
                    r.m <= wr_data[M_LSB +: M_W];
                    r.n <= wr_data[N_LSB +: N_W];
                end
                if (wr_addr == OFS_PSEL)
                    r.p <= wr_data[8*g +: P_W];
            end
        end
        assign bank_q[g] = r;
    end
endmodule

// File: rtl/dpll_ctl_regs.sv
module dpll_ctl_regs
    import dpll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [MISC_W-1:0] misc_q,
    output logic [DW-1:0]     lcdctl_q,
    output logic              sel_wr,
    output logic [1:0]        sel_code,
    output logic              lcd_on
);
    always_ff @(posedge clk) begin
        if (rst) begin
            misc_q   <= '0;
            lcdctl_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == OFS_MISC)   misc_q   <= wr_data[MISC_W-1:0];
            if (wr_addr == OFS_LCDCTL) lcdctl_q <= wr_data;
        end
    end

    assign sel_wr   = wr_en && (wr_addr == OFS_MISC);
    assign sel_code = wr_data[SEL_LSB +: 2];
    assign lcd_on   = lcdctl_q[DW-1] & lcdctl_q[0];
endmodule

// File: rtl/dpll_work_file.sv
module dpll_work_file
    import dpll_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  pll_par_t [N_SRC-1:0] bank_q,
    input  logic                 sel_wr,
    input  logic [1:0]           sel_code,
    input  logic                 lcd_on,
    output pll_par_t             work_q,
    output logic                 load_q,
    output logic [SRC_W-1:0]     src_q
);
    logic [SRC_W-1:0] nxt_src;
    logic             do_xfer;

    always_comb begin
        nxt_src = pick_src(sel_code, src_q, lcd_on);
        do_xfer = sel_wr && (lcd_on || sel_code != 2'b11);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= rst_par(0);
            src_q  <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= do_xfer;
            if (do_xfer) begin
                work_q <= bank_q[nxt_src];
                src_q  <= nxt_src;
            end
        end
    end

    // R9: a strobe only ever follows a select write
    a_r9_load_after_select: assert property (@(posedge clk) disable iff (rst)
        load_q |-> $past(sel_wr));
    // R7: the working file never moves without a strobe
    a_r7_work_held: assert property (@(posedge clk) disable iff (rst)
        !load_q |-> $stable(work_q));
    // R6: override forces the LCD set
    a_r6_lcd_override: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && lcd_on) |=> (load_q && src_q == SRC_LCD));
    // R5: reserved code is a no-op
    a_r5_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && !lcd_on && sel_code == 2'b11) |=> (!load_q && $stable(src_q)));
endmodule

// File: rtl/dpll_bank_sel.sv
module dpll_bank_sel
    import dpll_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [M_W-1:0]   pll_m,
    output logic [N_W-1:0]   pll_n,
    output logic [P_W-1:0]   pll_p,
    output logic             pll_load,
    output logic [SRC_W-1:0] pll_src
);
    pll_par_t [N_SRC-1:0] bank_q;
    pll_par_t             work_q;
    logic [MISC_W-1:0]    misc_q;
    logic [DW-1:0]        lcdctl_q;
    logic                 sel_wr;
    logic [1:0]           sel_code;
    logic                 lcd_on;

    dpll_bank_file u_banks (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bank_q(bank_q)
    );

    dpll_ctl_regs u_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .misc_q(misc_q), .lcdctl_q(lcdctl_q),
        .sel_wr(sel_wr), .sel_code(sel_code), .lcd_on(lcd_on)
    );

    dpll_work_file u_work (
        .clk(clk), .rst(rst), .bank_q(bank_q), .sel_wr(sel_wr),
        .sel_code(sel_code), .lcd_on(lcd_on), .work_q(work_q),
        .load_q(pll_load), .src_q(pll_src)
    );

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N_SRC; k++)
            if (rd_addr == OFS_DIV0 + AW'(k)) rd_data = pack_div(bank_q[k]);
        case (rd_addr)
            OFS_PSEL: for (int k = 0; k < N_SRC; k++) rd_data[8*k +: P_W] = bank_q[k].p;
            OFS_MISC:   rd_data = DW'(misc_q);
            OFS_LCDCTL: rd_data = lcdctl_q;
            OFS_WDIV:   rd_data = pack_div(work_q);
            OFS_WP:     rd_data = DW'(work_q.p);
            default: ;
        endcase
    end

    assign pll_m = work_q.m;
    assign pll_n = work_q.n;
    assign pll_p = work_q.p;
endmodule

// File: tb/dpll_bank_sel_bench.sv
module dpll_bank_sel_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [9:0]  pll_m;
    logic [9:0]  pll_n;
    logic [7:0]  pll_p;
    logic        pll_load;
    logic [1:0]  pll_src;

    always #5 clk = ~clk;

    dpll_bank_sel u_dpll_bank_sel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pll_m(pll_m), .pll_n(pll_n),
        .pll_p(pll_p), .pll_load(pll_load), .pll_src(pll_src)
    );

    int vectors = 0;
    int fails   = 0;
    logic [31:0] exp_q[$];          // {src[1:0], p[7:0], n[9:0], m[9:0]} packed
    logic [9:0] sm[4];
    logic [9:0] sn[4];
    logic [7:0] sp[4];
    logic [1:0] ssrc;
    logic [31:0] slcd;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] div_word(int k);
        return {6'b0, sn[k], 6'b0, sm[k]};
    endfunction

    task automatic wr(logic [3:0] a, logic [31:0] d);
        logic [1:0] ns;
        @(negedge clk);
        if (a <= 4'd3) begin sm[a] = d[9:0]; sn[a] = d[25:16]; end
        if (a == 4'd4) for (int k = 0; k < 4; k++) sp[k] = d[8*k +: 8];
        if (a == 4'd6) slcd = d;
        if (a == 4'd5) begin
            if (slcd[31] && slcd[0]) ns = 2'd3;
            else ns = d[3:2];
            if ((slcd[31] && slcd[0]) || d[3:2] != 2'b11) begin
                ssrc = ns;
                exp_q.push_back({2'b0, ns, sp[ns], sn[ns], sm[ns]});
            end
        end
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && pll_load) begin
            if (exp_q.size() == 0) begin
                vectors++; fails++;
                $display("FAIL R9: actual unexpected load expected none");
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check("R4/R6/R10 load", {2'b0, pll_src, pll_p, pll_n, pll_m}, e);
            end
        end
    end

    initial begin
        #1_000_000;
        vectors++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        sm = '{10'd103, 10'd170, 10'd0, 10'd0};
        sn = '{10'd20, 10'd30, 10'd0, 10'd0};
        sp = '{8'd2, 8'd2, 8'd0, 8'd0};
        ssrc = 2'd0; slcd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R3 reset state
        rd_chk("R3 div0", 4'd0, 32'h0014_0067);
        rd_chk("R3 div1", 4'd1, 32'h001E_00AA);
        rd_chk("R3 div2", 4'd2, 32'h0);
        rd_chk("R3 divlcd", 4'd3, 32'h0);
        rd_chk("R3 psel", 4'd4, 32'h0000_0202);
        rd_chk("R3 misc", 4'd5, 32'h0);
        rd_chk("R3 wdiv", 4'd7, 32'h0014_0067);
        rd_chk("R3 wp", 4'd8, 32'h2);
        check("R3 load", {31'b0, pll_load}, 32'h0);
        check("R3 src", {30'b0, pll_src}, 32'h0);
        // R1 field positions, other banks untouched
        wr(4'd2, 32'hFC55_FD33);
        rd_chk("R1 div2", 4'd2, 32'h0055_0133);
        rd_chk("R1 div0 kept", 4'd0, 32'h0014_0067);
        // R2 byte lanes
        wr(4'd4, 32'h0A07_0302);
        rd_chk("R2 psel", 4'd4, 32'h0A07_0302);
        // R4 select bank 2
        wr(4'd5, 32'h0000_0008);
        rd_chk("R8 wdiv bank2", 4'd7, 32'h0055_0133);
        rd_chk("R8 wp bank2", 4'd8, 32'h7);
        // R7 edit active bank, no change until reselect
        wr(4'd2, 32'h0001_0011);
        wr(4'd4, 32'h0A09_0302);
        rd_chk("R7 wdiv held", 4'd7, 32'h0055_0133);
        check("R7 pll_p held", {24'b0, pll_p}, 32'h7);
        wr(4'd5, 32'h0000_0008);
        rd_chk("R7 wdiv reloaded", 4'd7, 32'h0001_0011);
        // R4 banks 1 and 0, back to back
        wr(4'd5, 32'h0000_0004);
        wr(4'd5, 32'h0000_0000);
        // R5 reserved code
        wr(4'd5, 32'h0000_00FC);
        @(negedge clk);
        check("R5 src kept", {30'b0, pll_src}, 32'h0);
        rd_chk("R5 misc rb", 4'd5, 32'h0000_00FC);
        // R6 override
        wr(4'd3, 32'h0033_0044);
        wr(4'd6, 32'h8000_0001);
        rd_chk("R7 no load on ctl", 4'd7, 32'h0014_0067);
        wr(4'd5, 32'h0000_0004);
        check("R10 src lcd", {30'b0, pll_src}, 32'h3);
        wr(4'd5, 32'h0000_000C);
        wr(4'd6, 32'h8000_0000);
        wr(4'd5, 32'h0000_0004);
        check("R6 bit0 clear -> bank1", {30'b0, pll_src}, 32'h1);
        // R8 read-only working file
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        rd_chk("R8 wdiv ro", 4'd7, 32'h001E_00AA);
        rd_chk("R8 wp ro", 4'd8, 32'h3);
        rd_chk("R8 unmapped", 4'd12, 32'h0);
        repeat (3) @(negedge clk);
        check("R9 all loads seen", exp_q.size(), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule